// File: doc/BRIEF.md
# Reorder Buffer Retirement Controller

This block keeps a circular buffer of in-flight instructions, held only as sequence numbers and status bits, and retires them strictly in program order. Each cycle the rename stage offers a small group of instructions for the tail. Execute writebacks, identified by sequence number, mark entries complete. The head of the buffer retires completed entries, up to a fixed number per cycle. The occupancy is reported back as a free-entry count, and the block also reports the sequence number of the last instruction that retired.

A misprediction from execute carries the boundary sequence number and a redirect address. When the block accepts it, it announces the squash at once. It then spends several cycles walking back from the youngest entry, flagging every entry younger than the boundary as squashed. While the walk runs, nothing is inserted and nothing retires. Flagged entries stay in the buffer. They leave from the head without touching architectural state, and only once execute has written them back.

Memory, non-speculative and no-op entries are not executed early. Such an entry is released when it reaches the head, and the block emits a one-cycle pulse carrying its sequence number. An entry that holds a fault, or that is flagged as serializing or as a barrier, is never retired. It stops the head and raises a sticky error flag.

Top module: `rob_retire_ctl`

## Requirements
- R1: After reset the buffer is empty (free count 16), the error flag, the squash busy flag and all pulses are low, and `in_ready` is high.
- R2: While running, the slots of `ren_valid` are taken from slot 0 upward, and the group ends at the first slot whose valid bit is 0. Slots past that gap are dropped. Accepted entries join the tail in slot order, and the free count falls by their number after the edge.
- R3: `in_ready` is low, and no entry is inserted, when the number of leading valid slots exceeds the free count, when a squash walk is in progress, or when `sq_req` is high in the running state.
- R4: Retirement runs from the head in order. At most 2 entries retire per cycle, and retirement stops at the first entry that cannot leave. After the edge, `cm_cnt` gives the number retired and `last_seq` gives the newest non-squashed retired sequence number.
- R5: Up to 2 writeback slots per cycle mark matching entries complete. Marking also happens during a squash walk. An entry marked at an edge can retire at the following edge at the earliest.
- R6: A squash request accepted in the running state raises `sq_pulse` for exactly one cycle after the edge. In that same cycle `sq_busy` is high, and `sq_seq_o` and `sq_pc_o` hold the request's boundary and redirect address.
- R7: Each cycle of a squash walk flags up to 2 of the youngest not-yet-visited entries whose sequence number is greater than the boundary, and `walk_seq` reports the oldest entry flagged so far. `sq_busy` falls after the first cycle in which the walk meets an entry that is not younger, or runs out of entries. No retirement and no insertion happen during the walk.
- R8: A squash request that arrives while a walk is in progress is ignored. No pulse is raised and `sq_seq_o` keeps its value.
- R9: A squashed entry at the head retires only after it has been written back. It counts toward the width of 2, and it changes neither `last_seq` nor the execute-at-head pulse.
- R10: `ren_kind` is coded 0 plain, 1 memory, 2 non-speculative, 3 no-op. A kind other than 0 retires at the head without a writeback and ends retirement for that cycle. After the edge, `xh_pulse` is high for one cycle with `xh_seq` set. `xh_wake` is high for kinds 1 and 2 and low for kind 3.
- R11: A head entry written back with a fault, or inserted with its `ren_serial` bit set, is not retired. `err_o` goes high and stays high until reset, and the entry blocks the head.
- R12: `free_cnt` equals 16 minus the number of occupied entries in every cycle, and it never exceeds 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ren_valid | input | 2 | Per-slot valid of the rename group |
| ren_seq | input | 32 | Per-slot sequence number, slot i at bits 16i+15..16i |
| ren_kind | input | 4 | Per-slot kind code, slot i at bits 2i+1..2i |
| ren_serial | input | 2 | Per-slot serializing/barrier flag |
| in_ready | output | 1 | Group is accepted at this edge |
| wb_valid | input | 2 | Per-slot writeback valid |
| wb_seq | input | 32 | Per-slot writeback sequence number |
| wb_fault | input | 2 | Per-slot writeback fault flag |
| sq_req | input | 1 | Squash request from execute |
| sq_seq | input | 16 | Sequence number of the mispredicting instruction |
| sq_pc | input | 32 | Redirect address |
| free_cnt | output | 5 | Free buffer entries |
| cm_cnt | output | 2 | Entries retired at the last edge |
| last_seq | output | 16 | Newest non-squashed retired sequence number |
| xh_pulse | output | 1 | Execute-at-head release pulse |
| xh_seq | output | 16 | Sequence number of the released entry |
| xh_wake | output | 1 | Dependents wake-up indication |
| sq_pulse | output | 1 | Squash announce pulse |
| sq_busy | output | 1 | Squash walk in progress |
| sq_seq_o | output | 16 | Boundary of the accepted squash |
| sq_pc_o | output | 32 | Redirect address of the accepted squash |
| walk_seq | output | 16 | Oldest entry flagged so far by the walk |
| err_o | output | 1 | Sticky fault/serialize error |

## Verification
Any damaged pointer or count shows up as a wrong `free_cnt` in the cycle right after the edge that caused it. It also shows up as a wrong `cm_cnt` or `last_seq` at the next retirement. A walk that flags too few or too many entries is caught in two ways. The per-cycle `walk_seq` and the cycle in which `sq_busy` falls are both checked. An over-squashed entry also retires without advancing `last_seq`. A lost writeback or a missing squashed flag stalls retirement, and the next sampled `cm_cnt` exposes it within one cycle.

// File: rtl/rob_pkg.sv
`timescale 1ns/1ps
package rob_pkg;

    localparam int SEQ_W = 16;

    typedef enum logic [1:0] {
        K_PLAIN   = 2'd0,
        K_MEM     = 2'd1,
        K_NONSPEC = 2'd2,
        K_NOP     = 2'd3
    } kind_e;

    typedef enum logic {
        ST_RUN    = 1'b0,
        ST_SQUASH = 1'b1
    } ctl_state_e;

    typedef struct packed {
        logic             valid;
        logic             done;
        logic             squashed;
        logic             fault;
        logic             serial;
        kind_e            kind;
        logic [SEQ_W-1:0] seq;
    } rob_entry_t;

    function automatic logic held_to_head(kind_e k);
        return k != K_PLAIN;
    endfunction

    function automatic logic wakes_deps(kind_e k);
        return (k == K_MEM) || (k == K_NONSPEC);
    endfunction

endpackage

// File: rtl/rob_insert_ctl.sv
`timescale 1ns/1ps
module rob_insert_ctl #(
    parameter int RN_W = 2,
    parameter int CW   = 5,
    parameter int NW   = 2
) (
    input  logic [RN_W-1:0] ren_valid,
    input  logic [CW-1:0]   free,
    input  logic            enable,
    output logic [NW-1:0]   n_ins,
    output logic            ready
);
    logic stop;

    always_comb begin
        n_ins = '0;
        stop  = 1'b0;
        for (int i = 0; i < RN_W; i++) begin
            if (!stop) begin
                if (ren_valid[i]) n_ins = n_ins + NW'(1);
                else              stop  = 1'b1;
            end
        end
        ready = enable && (CW'(n_ins) <= free);
    end
endmodule

// File: rtl/rob_retire_sel.sv
`timescale 1ns/1ps
module rob_retire_sel
    import rob_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = 4,
    parameter int CW    = 5,
    parameter int CM_W  = 2,
    parameter int MW    = 2
) (
    input  rob_entry_t       ent [DEPTH],
    input  logic [AW-1:0]    head,
    input  logic [CW-1:0]    count,
    input  logic             enable,
    output logic [MW-1:0]    n_ret,
    output logic             upd_last,
    output logic [SEQ_W-1:0] last_seq_n,
    output logic             xh_fire,
    output logic [SEQ_W-1:0] xh_seq_n,
    output logic             xh_wake_n,
    output logic             err_hit
);
    logic          go;
    logic [AW-1:0] idx;
    rob_entry_t    e;

    always_comb begin
        n_ret      = '0;
        upd_last   = 1'b0;
        last_seq_n = '0;
        xh_fire    = 1'b0;
        xh_seq_n   = '0;
        xh_wake_n  = 1'b0;
        err_hit    = 1'b0;
        go         = enable;
        idx        = head;
        e          = ent[head];
        for (int i = 0; i < CM_W; i++) begin
            idx = head + AW'(i);
            e   = ent[idx];
            if (go && (CW'(i) < count)) begin
                if (e.squashed) begin
                    if (e.done) n_ret = n_ret + MW'(1);
                    else        go    = 1'b0;
                end else if (e.fault || e.serial) begin
                    err_hit = 1'b1;
                    go      = 1'b0;
                end else if (held_to_head(e.kind)) begin
                    n_ret      = n_ret + MW'(1);
                    upd_last   = 1'b1;
                    last_seq_n = e.seq;
                    xh_fire    = 1'b1;
                    xh_seq_n   = e.seq;
                    xh_wake_n  = wakes_deps(e.kind);
                    go         = 1'b0;
                end else if (e.done) begin
                    n_ret      = n_ret + MW'(1);
                    upd_last   = 1'b1;
                    last_seq_n = e.seq;
                end else begin
                    go = 1'b0;
                end
            end else begin
                go = 1'b0;
            end
        end
    end
endmodule

// File: rtl/rob_squash_walk.sv
`timescale 1ns/1ps
module rob_squash_walk
    import rob_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = 4,
    parameter int CW    = 5,
    parameter int SQ_W  = 2,
    parameter int WW    = 2
) (
    input  rob_entry_t       ent [DEPTH],
    input  logic [AW-1:0]    wp,
    input  logic [CW-1:0]    rem,
    input  logic [SEQ_W-1:0] bseq,
    output logic [WW-1:0]    n_mark,
    output logic             fin,
    output logic             front_vld,
    output logic [SEQ_W-1:0] front_seq
);
    logic          go;
    logic [AW-1:0] idx;

    always_comb begin
        n_mark    = '0;
        front_vld = 1'b0;
        front_seq = '0;
        go        = 1'b1;
        idx       = wp;
        for (int j = 0; j < SQ_W; j++) begin
            idx = wp - AW'(j);
            if (go && (CW'(j) < rem) && (ent[idx].seq > bseq)) begin
                n_mark    = n_mark + WW'(1);
                front_vld = 1'b1;
                front_seq = ent[idx].seq;
            end else begin
                go = 1'b0;
            end
        end
        fin = !go || (CW'(n_mark) == rem);
    end
endmodule

// File: rtl/rob_retire_ctl.sv
`timescale 1ns/1ps
module rob_retire_ctl
    import rob_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int RN_W  = 2,
    parameter int EX_W  = 2,
    parameter int CM_W  = 2,
    parameter int SQ_W  = 2,
    parameter int PC_W  = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1,
    localparam int NW   = $clog2(RN_W + 1),
    localparam int MW   = $clog2(CM_W + 1),
    localparam int WW   = $clog2(SQ_W + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [RN_W-1:0]       ren_valid,
    input  logic [RN_W*SEQ_W-1:0] ren_seq,
    input  logic [RN_W*2-1:0]     ren_kind,
    input  logic [RN_W-1:0]       ren_serial,
    output logic                  in_ready,
    input  logic [EX_W-1:0]       wb_valid,
    input  logic [EX_W*SEQ_W-1:0] wb_seq,
    input  logic [EX_W-1:0]       wb_fault,
    input  logic                  sq_req,
    input  logic [SEQ_W-1:0]      sq_seq,
    input  logic [PC_W-1:0]       sq_pc,
    output logic [CW-1:0]         free_cnt,
    output logic [MW-1:0]         cm_cnt,
    output logic [SEQ_W-1:0]      last_seq,
    output logic                  xh_pulse,
    output logic [SEQ_W-1:0]      xh_seq,
    output logic                  xh_wake,
    output logic                  sq_pulse,
    output logic                  sq_busy,
    output logic [SEQ_W-1:0]      sq_seq_o,
    output logic [PC_W-1:0]       sq_pc_o,
    output logic [SEQ_W-1:0]      walk_seq,
    output logic                  err_o
);
    rob_entry_t       ent [DEPTH];
    logic [AW-1:0]    head, tail, wp;
    logic [CW-1:0]    count, rem;
    logic [SEQ_W-1:0] bseq;
    ctl_state_e       state;

    logic [NW-1:0]    n_ins;
    logic             ins_ok;
    logic [MW-1:0]    n_ret;
    logic             upd_last, xh_fire, xh_wake_n, err_hit;
    logic [SEQ_W-1:0] last_seq_n, xh_seq_n;
    logic [WW-1:0]    n_mark;
    logic             fin, front_vld;
    logic [SEQ_W-1:0] front_seq;
    logic             run_now;

    assign run_now  = (state == ST_RUN) && !sq_req;
    assign free_cnt = CW'(DEPTH) - count;
    assign sq_busy  = (state == ST_SQUASH);
    assign in_ready = ins_ok;

    rob_insert_ctl #(.RN_W(RN_W), .CW(CW), .NW(NW)) u_ins (
        .ren_valid (ren_valid),
        .free      (free_cnt),
        .enable    (run_now),
        .n_ins     (n_ins),
        .ready     (ins_ok)
    );

    rob_retire_sel #(.DEPTH(DEPTH), .AW(AW), .CW(CW), .CM_W(CM_W), .MW(MW)) u_ret (
        .ent        (ent),
        .head       (head),
        .count      (count),
        .enable     (run_now),
        .n_ret      (n_ret),
        .upd_last   (upd_last),
        .last_seq_n (last_seq_n),
        .xh_fire    (xh_fire),
        .xh_seq_n   (xh_seq_n),
        .xh_wake_n  (xh_wake_n),
        .err_hit    (err_hit)
    );

    rob_squash_walk #(.DEPTH(DEPTH), .AW(AW), .CW(CW), .SQ_W(SQ_W), .WW(WW)) u_walk (
        .ent       (ent),
        .wp        (wp),
        .rem       (rem),
        .bseq      (bseq),
        .n_mark    (n_mark),
        .fin       (fin),
        .front_vld (front_vld),
        .front_seq (front_seq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int d = 0; d < DEPTH; d++) ent[d] <= '0;
            head     <= '0;
            tail     <= '0;
            wp       <= '0;
            count    <= '0;
            rem      <= '0;
            bseq     <= '0;
            state    <= ST_RUN;
            cm_cnt   <= '0;
            last_seq <= '0;
            xh_pulse <= 1'b0;
            xh_seq   <= '0;
            xh_wake  <= 1'b0;
            sq_pulse <= 1'b0;
            sq_seq_o <= '0;
            sq_pc_o  <= '0;
            walk_seq <= '0;
            err_o    <= 1'b0;
        end else begin
            cm_cnt   <= '0;
            xh_pulse <= 1'b0;
            xh_wake  <= 1'b0;
            sq_pulse <= 1'b0;

            // completion marking runs in every state
            for (int k = 0; k < EX_W; k++) begin
                if (wb_valid[k]) begin
                    for (int d = 0; d < DEPTH; d++) begin
                        if (ent[d].valid && ent[d].seq == wb_seq[k*SEQ_W +: SEQ_W]) begin
                            ent[d].done  <= 1'b1;
                            ent[d].fault <= wb_fault[k];
                        end
                    end
                end
            end

            if (state == ST_RUN) begin
                if (sq_req) begin
                    state    <= ST_SQUASH;
                    sq_pulse <= 1'b1;
                    sq_seq_o <= sq_seq;
                    sq_pc_o  <= sq_pc;
                    bseq     <= sq_seq;
                    wp       <= tail - AW'(1);
                    rem      <= count;
                end else begin
                    cm_cnt <= n_ret;
                    for (int i = 0; i < CM_W; i++) begin
                        if (MW'(i) < n_ret) ent[head + AW'(i)].valid <= 1'b0;
                    end
                    head <= head + AW'(n_ret);
                    if (upd_last) last_seq <= last_seq_n;
                    if (xh_fire) begin
                        xh_pulse <= 1'b1;
                        xh_seq   <= xh_seq_n;
                        xh_wake  <= xh_wake_n;
                    end
                    if (err_hit) err_o <= 1'b1;
                    if (ins_ok) begin
                        for (int i = 0; i < RN_W; i++) begin
                            if (NW'(i) < n_ins) begin
                                ent[tail + AW'(i)].valid    <= 1'b1;
                                ent[tail + AW'(i)].done     <= 1'b0;
                                ent[tail + AW'(i)].squashed <= 1'b0;
                                ent[tail + AW'(i)].fault    <= 1'b0;
                                ent[tail + AW'(i)].serial   <= ren_serial[i];
                                ent[tail + AW'(i)].kind     <= kind_e'(ren_kind[2*i +: 2]);
                                ent[tail + AW'(i)].seq      <= ren_seq[i*SEQ_W +: SEQ_W];
                            end
                        end
                        tail  <= tail + AW'(n_ins);
                        count <= count - CW'(n_ret) + CW'(n_ins);
                    end else begin
                        count <= count - CW'(n_ret);
                    end
                end
            end else begin
                for (int j = 0; j < SQ_W; j++) begin
                    if (WW'(j) < n_mark) ent[wp - AW'(j)].squashed <= 1'b1;
                end
                wp  <= wp - AW'(n_mark);
                rem <= rem - CW'(n_mark);
                if (front_vld) walk_seq <= front_seq;
                if (fin) state <= ST_RUN;
            end
        end
    end
endmodule

// File: rtl/rob_retire_chk.sv
`timescale 1ns/1ps
module rob_retire_chk #(
    parameter int DEPTH = 16,
    parameter int CM_W  = 2,
    parameter int CW    = 5,
    parameter int MW    = 2
) (
    input logic          clk,
    input logic          rst,
    input logic          in_ready,
    input logic [CW-1:0] free_cnt,
    input logic [MW-1:0] cm_cnt,
    input logic          xh_pulse,
    input logic          xh_wake,
    input logic          sq_pulse,
    input logic          sq_busy,
    input logic          err_o
);
    assert_no_overflow_R12: assert property (@(posedge clk) disable iff (rst)
        free_cnt <= CW'(DEPTH));

    assert_width_R4: assert property (@(posedge clk) disable iff (rst)
        cm_cnt <= MW'(CM_W));

    assert_refuse_R3: assert property (@(posedge clk) disable iff (rst)
        !in_ready |=> free_cnt >= $past(free_cnt));

    assert_walk_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        sq_busy |=> cm_cnt == '0);

    assert_pulse_busy_R6: assert property (@(posedge clk) disable iff (rst)
        sq_pulse |-> sq_busy);

    assert_pulse_once_R6: assert property (@(posedge clk) disable iff (rst)
        sq_pulse |=> !sq_pulse);

    assert_ignore_R8: assert property (@(posedge clk) disable iff (rst)
        sq_busy |=> !sq_pulse);

    assert_wake_R10: assert property (@(posedge clk) disable iff (rst)
        xh_wake |-> xh_pulse);

    assert_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        err_o |=> err_o);
endmodule

bind rob_retire_ctl rob_retire_chk #(
    .DEPTH(DEPTH), .CM_W(CM_W), .CW(CW), .MW(MW)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_ready (in_ready),
    .free_cnt (free_cnt),
    .cm_cnt   (cm_cnt),
    .xh_pulse (xh_pulse),
    .xh_wake  (xh_wake),
    .sq_pulse (sq_pulse),
    .sq_busy  (sq_busy),
    .err_o    (err_o)
);

// File: tb/sim_rob_retire_ctl.sv
`timescale 1ns/1ps
module sim_rob_retire_ctl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  ren_valid = '0;
    logic [31:0] ren_seq = '0;
    logic [3:0]  ren_kind = '0;
    logic [1:0]  ren_serial = '0;
    logic        in_ready;
    logic [1:0]  wb_valid = '0;
    logic [31:0] wb_seq = '0;
    logic [1:0]  wb_fault = '0;
    logic        sq_req = 1'b0;
    logic [15:0] sq_seq = '0;
    logic [31:0] sq_pc = '0;
    logic [4:0]  free_cnt;
    logic [1:0]  cm_cnt;
    logic [15:0] last_seq;
    logic        xh_pulse;
    logic [15:0] xh_seq;
    logic        xh_wake;
    logic        sq_pulse;
    logic        sq_busy;
    logic [15:0] sq_seq_o;
    logic [31:0] sq_pc_o;
    logic [15:0] walk_seq;
    logic        err_o;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    rob_retire_ctl u0 (
        .clk(clk), .rst(rst),
        .ren_valid(ren_valid), .ren_seq(ren_seq), .ren_kind(ren_kind),
        .ren_serial(ren_serial), .in_ready(in_ready),
        .wb_valid(wb_valid), .wb_seq(wb_seq), .wb_fault(wb_fault),
        .sq_req(sq_req), .sq_seq(sq_seq), .sq_pc(sq_pc),
        .free_cnt(free_cnt), .cm_cnt(cm_cnt), .last_seq(last_seq),
        .xh_pulse(xh_pulse), .xh_seq(xh_seq), .xh_wake(xh_wake),
        .sq_pulse(sq_pulse), .sq_busy(sq_busy), .sq_seq_o(sq_seq_o),
        .sq_pc_o(sq_pc_o), .walk_seq(walk_seq), .err_o(err_o)
    );

    typedef struct packed {
        logic [1:0]  rv;
        logic [15:0] r0;
        logic [15:0] r1;
        logic [1:0]  wv;
        logic [15:0] w0;
        logic [15:0] w1;
        logic [4:0]  free;
        logic [1:0]  cm;
        logic [15:0] last;
    } row_t;

    localparam row_t TBL [8] = '{
        '{2'b11, 16'd1, 16'd2, 2'b00, 16'd0, 16'd0, 5'd14, 2'd0, 16'd0},
        '{2'b11, 16'd3, 16'd4, 2'b11, 16'd1, 16'd2, 5'd12, 2'd0, 16'd0},
        '{2'b00, 16'd0, 16'd0, 2'b01, 16'd4, 16'd0, 5'd14, 2'd2, 16'd2},
        '{2'b01, 16'd5, 16'd0, 2'b00, 16'd0, 16'd0, 5'd13, 2'd0, 16'd2},
        '{2'b10, 16'd0, 16'd6, 2'b01, 16'd3, 16'd0, 5'd13, 2'd0, 16'd2},
        '{2'b00, 16'd0, 16'd0, 2'b01, 16'd5, 16'd0, 5'd15, 2'd2, 16'd4},
        '{2'b00, 16'd0, 16'd0, 2'b00, 16'd0, 16'd0, 5'd16, 2'd1, 16'd5},
        '{2'b00, 16'd0, 16'd0, 2'b00, 16'd0, 16'd0, 5'd16, 2'd0, 16'd5}
    };

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        ren_valid = '0; ren_seq = '0; ren_kind = '0; ren_serial = '0;
        wb_valid = '0; wb_seq = '0; wb_fault = '0;
        sq_req = 1'b0; sq_seq = '0; sq_pc = '0;
    endtask

    task automatic set_ren(input logic [1:0] v, input logic [15:0] s0, input logic [15:0] s1,
                           input logic [1:0] k0, input logic [1:0] k1, input logic [1:0] ser);
        ren_valid = v; ren_seq = {s1, s0}; ren_kind = {k1, k0}; ren_serial = ser;
    endtask

    task automatic set_wb(input logic [1:0] v, input logic [15:0] s0, input logic [15:0] s1,
                          input logic [1:0] f);
        wb_valid = v; wb_seq = {s1, s0}; wb_fault = f;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        idle();
        tick();
        tick();
        rst = 1'b0;
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL R1 watchdog act=running exp=finished");
            summary();
            $finish;
        end
    end

    initial begin
        idle();
        do_reset();
        // R1 reset state
        chk("R1 free", free_cnt, 16);
        chk("R1 err", err_o, 0);
        chk("R1 busy", sq_busy, 0);
        chk("R1 xh", xh_pulse, 0);
        chk("R1 ready", in_ready, 1);

        // R2 R4 R5 table of stimulus rows
        for (int r = 0; r < 8; r++) begin
            idle();
            set_ren(TBL[r].rv, TBL[r].r0, TBL[r].r1, 2'd0, 2'd0, 2'b00);
            set_wb(TBL[r].wv, TBL[r].w0, TBL[r].w1, 2'b00);
            tick();
            chk($sformatf("R2 R12 row%0d free", r), free_cnt, TBL[r].free);
            chk($sformatf("R4 R5 row%0d cm", r), cm_cnt, TBL[r].cm);
            chk($sformatf("R4 row%0d last", r), last_seq, TBL[r].last);
        end

        // R3 fill to 15 entries, seq 10..24
        for (int g = 0; g < 7; g++) begin
            idle();
            set_ren(2'b11, 16'(10 + 2*g), 16'(11 + 2*g), 2'd0, 2'd0, 2'b00);
            tick();
        end
        idle();
        set_ren(2'b01, 16'd24, 16'd0, 2'd0, 2'd0, 2'b00);
        tick();
        chk("R12 free after fill", free_cnt, 1);
        idle();
        set_ren(2'b11, 16'd25, 16'd26, 2'd0, 2'd0, 2'b00);
        #0.5;
        chk("R3 ready low on overflow", in_ready, 0);
        tick();
        chk("R3 refused group free", free_cnt, 1);
        idle();
        set_ren(2'b01, 16'd25, 16'd0, 2'd0, 2'd0, 2'b00);
        tick();
        chk("R12 full free", free_cnt, 0);

        // R6 squash accept, boundary 19
        idle();
        sq_req = 1'b1; sq_seq = 16'd19; sq_pc = 32'h0000ABCD;
        tick();
        chk("R6 pulse", sq_pulse, 1);
        chk("R6 busy", sq_busy, 1);
        chk("R6 seq", sq_seq_o, 19);
        chk("R6 pc", sq_pc_o, 32'h0000ABCD);
        idle();
        set_ren(2'b01, 16'd99, 16'd0, 2'd0, 2'd0, 2'b00);
        #0.5;
        chk("R3 ready low while walking", in_ready, 0);
        tick();
        chk("R6 pulse one cycle", sq_pulse, 0);
        chk("R7 walk step1", walk_seq, 24);
        chk("R7 no retire in walk", cm_cnt, 0);
        idle();
        sq_req = 1'b1; sq_seq = 16'd5; sq_pc = 32'd1;
        set_wb(2'b01, 16'd10, 16'd0, 2'b00);
        tick();
        chk("R8 no new pulse", sq_pulse, 0);
        chk("R8 seq kept", sq_seq_o, 19);
        chk("R7 walk step2", walk_seq, 22);
        idle();
        tick();
        chk("R7 walk step3", walk_seq, 20);
        chk("R7 still busy", sq_busy, 1);
        tick();
        chk("R7 walk done", sq_busy, 0);
        chk("R7 walk held", walk_seq, 20);
        tick();
        chk("R5 wb during walk retires", cm_cnt, 1);
        chk("R5 last", last_seq, 10);

        // R9 squashed entries retire silently after writeback
        for (int s = 11; s <= 19; s += 2) begin
            idle();
            set_wb(2'b11, 16'(s), 16'(s + 1), 2'b00);
            tick();
        end
        idle();
        set_wb(2'b01, 16'd21, 16'd0, 2'b00);
        tick();
        chk("R9 mixed retire cm", cm_cnt, 2);
        chk("R9 last not advanced by squashed", last_seq, 19);
        chk("R12 free", free_cnt, 11);
        idle();
        tick();
        chk("R9 squashed done retires", cm_cnt, 1);
        tick();
        chk("R9 unexecuted squashed waits", cm_cnt, 0);
        chk("R9 free held", free_cnt, 12);
        set_wb(2'b11, 16'd22, 16'd23, 2'b00);
        tick();
        set_wb(2'b11, 16'd24, 16'd25, 2'b00);
        tick();
        chk("R9 pair retire", cm_cnt, 2);
        idle();
        tick();
        chk("R9 drained free", free_cnt, 16);
        chk("R9 last", last_seq, 19);
        chk("R9 no xh", xh_pulse, 0);

        // R10 execute-at-head kinds
        idle();
        set_ren(2'b11, 16'd40, 16'd41, 2'd1, 2'd3, 2'b00);
        tick();
        idle();
        set_ren(2'b11, 16'd42, 16'd43, 2'd0, 2'd2, 2'b00);
        tick();
        chk("R10 mem cm", cm_cnt, 1);
        chk("R10 mem pulse", xh_pulse, 1);
        chk("R10 mem seq", xh_seq, 40);
        chk("R10 mem wake", xh_wake, 1);
        idle();
        tick();
        chk("R10 nop cm", cm_cnt, 1);
        chk("R10 nop seq", xh_seq, 41);
        chk("R10 nop no wake", xh_wake, 0);
        chk("R10 nop last", last_seq, 41);
        set_wb(2'b01, 16'd42, 16'd0, 2'b00);
        tick();
        chk("R10 plain waits", cm_cnt, 0);
        chk("R10 pulse clear", xh_pulse, 0);
        idle();
        tick();
        chk("R10 plain then nonspec", cm_cnt, 2);
        chk("R10 nonspec seq", xh_seq, 43);
        chk("R10 nonspec wake", xh_wake, 1);
        chk("R10 last", last_seq, 43);

        // R11 serialize flag blocks the head
        idle();
        set_ren(2'b11, 16'd50, 16'd51, 2'd0, 2'd0, 2'b10);
        tick();
        idle();
        set_wb(2'b11, 16'd50, 16'd51, 2'b00);
        tick();
        idle();
        tick();
        chk("R11 older retires", cm_cnt, 1);
        chk("R11 err set", err_o, 1);
        tick();
        chk("R11 blocked", cm_cnt, 0);
        chk("R11 free", free_cnt, 15);
        chk("R11 sticky", err_o, 1);

        // R1 after reset, then R11 fault
        do_reset();
        chk("R1 free after reset", free_cnt, 16);
        chk("R1 err cleared", err_o, 0);
        idle();
        set_ren(2'b01, 16'd60, 16'd0, 2'd0, 2'd0, 2'b00);
        tick();
        idle();
        set_wb(2'b01, 16'd60, 16'd0, 2'b01);
        tick();
        idle();
        tick();
        chk("R11 fault not retired", cm_cnt, 0);
        chk("R11 fault err", err_o, 1);
        chk("R11 fault free", free_cnt, 15);

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule